// File: doc/BRIEF.md
# Nonvolatile Store Request Sequencer

This block decides when the contents of a fast volatile array are copied into the nonvolatile array behind it. Three sources may ask for a copy: an active-low request pin, a one-cycle software command, and a power-fail level. A dirty flag records whether any write has finished since the last copy or restore. Requests from the pin or from power-fail are dropped while the flag is clear. A software command always runs. A separate one-cycle pulse asks for a restore in the other direction.

An accepted store first opens a grace window of `DELAY_CYC` cycles. Reads still run during the window. A write already in flight may finish and report its write-done pulse, but no new write is admitted. The copy then runs for `STORE_CYC` cycles. For all of that time the active-low busy output is low and the array is disabled. If the request pin is still held low when the copy ends, the array stays disabled until the pin is seen high again. A restore disables the array for `RECALL_CYC` cycles and does not assert busy. The surrounding memory controller is expected to gate its read and write strobes with the enable outputs.

Top module: `nv_store_seq`

## Requirements
- R1: After synchronous reset, busy_n=1, mem_en=1, wr_allow=1 and the dirty flag is clear.
- R2: With the dirty flag set (by a wr_done pulse), holding hw_req_n low starts a store. The pin passes through one input register, so busy_n first reads 0 DELAY_CYC+2 cycles after the pin falls. A power-fail request that is held starts a store in the same way after DELAY_CYC+1 cycles.
- R3: While the dirty flag is clear, hw_req_n low or pwr_fail high never lowers busy_n and never lowers mem_en.
- R4: A one-cycle sw_store pulse always starts a store, even with the flag clear. busy_n first reads 0 DELAY_CYC+1 cycles after the pulse is driven.
- R5: During the grace window before a store, mem_en=1 and wr_allow=0.
- R6: wr_allow reads 0 from the second cycle after hw_req_n goes low, for as long as the pin stays low. It returns to 1 two cycles after the pin rises, provided the sequencer is idle.
- R7: busy_n stays low for exactly STORE_CYC consecutive cycles per store, and mem_en=0 throughout.
- R8: If hw_req_n is still low when a store ends, mem_en stays 0 and busy_n stays 1 until the pin has been seen high. mem_en returns to 1 two cycles after the pin rises.
- R9: The end of a store or a restore clears the dirty flag. A later pin request with no write in between is skipped.
- R10: A recall_req pulse drives mem_en=0 for exactly RECALL_CYC cycles with busy_n held at 1. A store request in the same cycle wins, and the restore is dropped.
- R11: Store requests from several sources in the same cycle merge into one store. If sw_store is among them, the store runs even when the flag is clear.
- R12: sw_store and recall_req pulses that arrive while a store, restore or grace window is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_n | input | 1 | Active-low hardware store request pin |
| sw_store | input | 1 | One-cycle software store command |
| pwr_fail | input | 1 | Power-fail indication, level |
| recall_req | input | 1 | One-cycle restore request |
| wr_done | input | 1 | Pulse marking a completed array write |
| busy_n | output | 1 | Active-low busy, low while a store runs |
| mem_en | output | 1 | Array enabled for reads |
| wr_allow | output | 1 | New writes may be admitted |

## Verification
Two pairs of functions can land in the same cycle. In the first, sw_store and pwr_fail are raised on the same edge while the flag is clear. This is judged by seeing exactly one busy-low run of STORE_CYC cycles and no second run afterwards. In the second, sw_store and recall_req arrive together. The test checks that a single store runs and that mem_en then stays high, which proves the restore was dropped.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOLD   = 3'd1,
    ST_STORE  = 3'd2,
    ST_RECALL = 3'd3,
    ST_LOCK   = 3'd4
  } nvs_state_t;
endpackage

// File: rtl/nvs_dirty.sv
module nvs_dirty (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  // a set wins over a clear so that no completed write is lost
  always_ff @(posedge clk) begin
    if (rst)        dirty_o <= 1'b0;
    else if (set_i) dirty_o <= 1'b1;
    else if (clr_i) dirty_o <= 1'b0;
  end
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvs_req_merge.sv
module nvs_req_merge (
  input  logic hw_low_i,
  input  logic pwr_fail_i,
  input  logic sw_store_i,
  input  logic recall_i,
  input  logic dirty_i,
  output logic store_go_o,
  output logic recall_go_o
);
  logic cond_req;

  always_comb begin
    cond_req    = (hw_low_i | pwr_fail_i) & dirty_i;
    store_go_o  = sw_store_i | cond_req;
    recall_go_o = recall_i & ~store_go_o;
  end
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
  parameter int DELAY_CYC  = 4,
  parameter int STORE_CYC  = 6,
  parameter int RECALL_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_req_n,
  input  logic sw_store,
  input  logic pwr_fail,
  input  logic recall_req,
  input  logic wr_done,
  output logic busy_n,
  output logic mem_en,
  output logic wr_allow
);
  import nvs_pkg::*;

  localparam int MAXC  = (DELAY_CYC > STORE_CYC) ?
                         ((DELAY_CYC > RECALL_CYC) ? DELAY_CYC : RECALL_CYC) :
                         ((STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] LD_STORE  = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RECALL = CNT_W'(RECALL_CYC - 1);

  nvs_state_t       state_q, state_n;
  logic             hw_q;
  logic             dirty;
  logic             store_go, recall_go;
  logic             tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             dirty_clr;
  logic             busy_n_q, mem_en_q, wr_allow_q;

  // input register for the request pin
  always_ff @(posedge clk) begin
    if (rst) hw_q <= 1'b1;
    else     hw_q <= hw_req_n;
  end

  nvs_req_merge u_merge (
    .hw_low_i   (~hw_q),
    .pwr_fail_i (pwr_fail),
    .sw_store_i (sw_store),
    .recall_i   (recall_req),
    .dirty_i    (dirty),
    .store_go_o (store_go),
    .recall_go_o(recall_go)
  );

  nvs_dirty u_dirty (
    .clk    (clk),
    .rst    (rst),
    .set_i  (wr_done),
    .clr_i  (dirty_clr),
    .dirty_o(dirty)
  );

  nvs_timer #(.W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  always_comb begin
    state_n   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    dirty_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (store_go) begin
          state_n  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end else if (recall_go) begin
          state_n  = ST_RECALL;
          tmr_load = 1'b1;
          tmr_val  = LD_RECALL;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          state_n  = ST_STORE;
          tmr_load = 1'b1;
          tmr_val  = LD_STORE;
        end
      end
      ST_STORE: begin
        if (tmr_zero) begin
          dirty_clr = 1'b1;
          state_n   = hw_q ? ST_IDLE : ST_LOCK;
        end
      end
      ST_RECALL: begin
        if (tmr_zero) begin
          dirty_clr = 1'b1;
          state_n   = ST_IDLE;
        end
      end
      ST_LOCK: begin
        if (hw_q) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy_n_q   <= 1'b1;
      mem_en_q   <= 1'b1;
      wr_allow_q <= 1'b1;
    end else begin
      state_q    <= state_n;
      busy_n_q   <= (state_n != ST_STORE);
      mem_en_q   <= (state_n == ST_IDLE) || (state_n == ST_HOLD);
      wr_allow_q <= (state_n == ST_IDLE) && hw_q;
    end
  end

  assign busy_n   = busy_n_q;
  assign mem_en   = mem_en_q;
  assign wr_allow = wr_allow_q;
endmodule

// File: rtl/nv_store_seq_chk.sv
module nv_store_seq_chk #(
  parameter int STORE_CYC = 6
) (
  input logic clk,
  input logic rst,
  input logic hw_req_n,
  input logic busy_n,
  input logic mem_en,
  input logic wr_allow
);
  logic [1:0]  armed;
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= '0;
      low_run <= '0;
    end else begin
      if (armed != 2'd3) armed <= armed + 1'b1;
      low_run <= busy_n ? 32'd0 : low_run + 1;
    end
  end

  // R7: array disabled whenever busy is asserted
  a_r7_store_mem_off: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> !mem_en);

  // R7: a busy-low run never exceeds the store length
  a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
    low_run <= STORE_CYC);

  // R6: pin low two cycles earlier blocks new writes
  a_r6_pin_inhibit: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd3) && !$past(hw_req_n, 2) |-> !wr_allow);

  // R5: a store is always preceded by a window with writes blocked
  a_r5_hold_first: assert property (@(posedge clk) disable iff (rst)
    (armed != 2'd0) && $fell(busy_n) |-> !$past(wr_allow));

  // R8: disabled array never admits writes
  a_r8_no_wr_when_off: assert property (@(posedge clk) disable iff (rst)
    !mem_en |-> !wr_allow);
endmodule

bind nv_store_seq nv_store_seq_chk #(.STORE_CYC(STORE_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hw_req_n(hw_req_n),
  .busy_n  (busy_n),
  .mem_en  (mem_en),
  .wr_allow(wr_allow)
);

// File: tb/nv_store_seq_test.sv
module nv_store_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;
  localparam int S = 6;
  localparam int RC = 3;

  logic clk = 1'b0;
  logic rst, hw_req_n, sw_store, pwr_fail, recall_req, wr_done;
  logic busy_n, mem_en, wr_allow;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_store_seq #(.DELAY_CYC(D), .STORE_CYC(S), .RECALL_CYC(RC)) uut (
    .clk(clk), .rst(rst), .hw_req_n(hw_req_n), .sw_store(sw_store),
    .pwr_fail(pwr_fail), .recall_req(recall_req), .wr_done(wr_done),
    .busy_n(busy_n), .mem_en(mem_en), .wr_allow(wr_allow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_write();
    wr_done = 1'b1; tick(); wr_done = 1'b0;
  endtask

  // count negedges until busy_n is low; 0 if never within limit
  task automatic wait_busy(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (!busy_n) begin n = i; return; end
    end
  endtask

  // length of the busy-low run already under way (first low just seen)
  task automatic busy_run(output int len);
    len = 1;
    while (len < 100) begin
      tick();
      if (busy_n) return;
      len++;
    end
  endtask

  task automatic watch(input int n, output int busy_lows, output int mem_lows);
    busy_lows = 0; mem_lows = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (!busy_n) busy_lows++;
      if (!mem_en) mem_lows++;
    end
  endtask

  task automatic t_reset_and_clean_pin();
    int b, m;
    chk("R1 busy_n", busy_n, 1);
    chk("R1 mem_en", mem_en, 1);
    chk("R1 wr_allow", wr_allow, 1);
    hw_req_n = 1'b0;
    tick(); tick();
    chk("R6 wr_allow low", wr_allow, 0);
    watch(12, b, m);
    chk("R3 clean pin busy", b, 0);
    chk("R3 clean pin mem_en", m, 0);
    hw_req_n = 1'b1;
    tick(); tick(); tick();
    chk("R6 wr_allow back", wr_allow, 1);
  endtask

  task automatic t_hw_store();
    int n, len, b, m;
    pulse_write();
    hw_req_n = 1'b0;
    tick(); tick(); tick();
    chk("R5 hold mem_en", mem_en, 1);
    chk("R5 hold wr_allow", wr_allow, 0);
    wait_busy(40, n);
    chk("R2 hw delay", n + 3, D + 2);
    chk("R7 mem_en off in store", mem_en, 0);
    busy_run(len);
    chk("R7 store length", len, S);
    watch(5, b, m);
    chk("R8 lock busy", b, 0);
    chk("R8 lock mem_en", m, 5);
    hw_req_n = 1'b1;
    tick(); tick();
    chk("R8 release mem_en", mem_en, 1);
    hw_req_n = 1'b0;
    watch(15, b, m);
    chk("R9 no store after clear", b, 0);
    hw_req_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic t_sw_clean();
    int n, len;
    sw_store = 1'b1; tick(); sw_store = 1'b0;
    wait_busy(40, n);
    chk("R4 sw delay", n + 1, D + 1);
    busy_run(len);
    chk("R4 sw store length", len, S);
    tick();
    chk("R4 mem_en after store", mem_en, 1);
  endtask

  task automatic t_pwr_fail();
    int n, len, b, m;
    pwr_fail = 1'b1;
    watch(15, b, m);
    chk("R3 clean pwr_fail", b, 0);
    pwr_fail = 1'b0; tick();
    pulse_write();
    pwr_fail = 1'b1;
    wait_busy(40, n);
    chk("R2 pwr_fail delay", n, D + 1);
    busy_run(len);
    chk("R7 pwr store length", len, S);
    watch(10, b, m);
    chk("R9 held pwr_fail no repeat", b, 0);
    pwr_fail = 1'b0; tick();
  endtask

  task automatic t_recall();
    int b, m;
    pulse_write();
    recall_req = 1'b1; tick(); recall_req = 1'b0;
    chk("R10 recall mem_en", mem_en, 0);
    m = 1; b = busy_n ? 0 : 1;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (!mem_en) m++;
      if (!busy_n) b++;
    end
    chk("R10 recall length", m, RC);
    chk("R10 recall busy", b, 0);
    hw_req_n = 1'b0;
    watch(15, b, m);
    chk("R9 recall clears dirty", b, 0);
    hw_req_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic t_merge();
    int n, len, b, m;
    sw_store = 1'b1; pwr_fail = 1'b1; tick();
    sw_store = 1'b0; pwr_fail = 1'b0;
    wait_busy(40, n);
    chk("R11 merged delay", n + 1, D + 1);
    busy_run(len);
    chk("R11 merged length", len, S);
    watch(20, b, m);
    chk("R11 single store", b, 0);
    sw_store = 1'b1; recall_req = 1'b1; tick();
    sw_store = 1'b0; recall_req = 1'b0;
    wait_busy(40, n);
    chk("R10 store wins", n + 1, D + 1);
    busy_run(len);
    watch(12, b, m);
    chk("R10 recall dropped", m, 0);
  endtask

  task automatic t_drop();
    int n, len, b, m;
    sw_store = 1'b1; tick(); sw_store = 1'b0;
    tick();
    sw_store = 1'b1; tick(); sw_store = 1'b0;
    wait_busy(40, n);
    recall_req = 1'b1; sw_store = 1'b1; tick();
    recall_req = 1'b0; sw_store = 1'b0;
    while (!busy_n) tick();
    watch(20, b, m);
    chk("R12 dropped busy", b, 0);
    chk("R12 dropped mem_en", m, 0);
  endtask

  initial begin
    rst = 1'b1; hw_req_n = 1'b1; sw_store = 1'b0; pwr_fail = 1'b0;
    recall_req = 1'b0; wr_done = 1'b0;
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    t_reset_and_clean_pin();
    t_hw_store();
    t_sw_clean();
    t_pwr_fail();
    t_recall();
    t_merge();
    t_drop();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule